// File: doc/BRIEF.md
# Character-Synchronous Block Receiver with Check-Sequence Validation

This block takes received characters as bytes and works on them one byte per strobe. After a reset or an initialize pulse it hunts for character framing. Once it has that framing it delimits each frame. It tells apart text frames, transparent frames and control frames without a check sequence. For frames that carry a check sequence it accumulates an LRC or a CRC-16 and compares it with the received one. Bit-level clock recovery is done elsewhere. Only the ASCII control set is decoded.

Frame payload leaves the block as a byte with a one-cycle valid. When a frame ends, a one-cycle end-of-frame pulse comes out together with two qualifiers: check mismatch and abort. An end-of-frame pulse with neither qualifier marks a good frame. A programmable terminator byte can close a frame at once, without any check. Setting it to 0xFF lets the block notice a line that has dropped back to idle in the middle of a frame.

The controller has ten states. It moves from ST_HUNT to ST_SYN1 on a SYN. From ST_SYN1 it goes to ST_SYNC on a second SYN, and back to ST_HUNT on anything else. ST_SYNC discards further SYNs. On the first other byte it enters one of three states: ST_TEXT (SOH/STX), ST_XSTART (DLE), or ST_NOBCC (any other byte). ST_XSTART goes to ST_TRANS on STX, and otherwise aborts to ST_HUNT. ST_TRANS goes to ST_TRANS_DLE on a DLE, and ST_TRANS_DLE returns to ST_TRANS after the escaped byte. ST_TEXT and ST_TRANS_DLE go to ST_CHK1 on a block end. ST_CHK1 goes to ST_CHK2 in CRC mode. Every termination returns the controller to ST_HUNT.

Top module: `bisync_rx`

## Requirements
- R1: After reset or a one-cycle `init` pulse, `hunting` is 1 and nothing is delivered. Bytes are discarded until two strobed SYN (0x16) bytes arrive back to back; any other byte between them restarts the hunt.
- R2: After the SYN pair, further SYNs are dropped, and the first other byte starts the frame. SOH (0x01) or STX (0x02) opens a text frame; the opening byte is delivered but kept out of the check. DLE (0x10) then STX opens a transparent frame: the DLE is dropped and the STX is delivered but kept out of the check. DLE followed by anything else ends the attempt with an abort. Any other first byte opens a frame without a check sequence.
- R3: Each delivered byte appears on `out_data` with `out_valid` high for exactly one cycle. That cycle is the one after the edge that sampled its strobe.
- R4: In text frames and frames without a check sequence, SYN bytes in the body are dropped and not counted in the check.
- R5: In a transparent frame, DLE DLE delivers one 0x10 data byte and counts one 0x10 in the check. DLE SYN is dropped. DLE followed by any other byte that is not a block end or ENQ delivers that byte as data.
- R6: In text frames, ETX (0x03) or ETB (0x17) ends the block; in transparent frames the same bytes do so only after a DLE. The block-end byte is delivered and counted, and the check bytes follow. The check bytes are not delivered; `eof` pulses with the last one, and `eof_bcc_err` is set on a mismatch. With `cfg_crc`=0 there is one check byte: the XOR of the counted bytes. With `cfg_crc`=1 there are two check bytes, low byte first. They hold a CRC-16 over the counted bytes: reflected polynomial 0xA001, initial value 0, LSB of each byte first.
- R7: ENQ (0x05) in a text or no-check body, or after DLE in a transparent body, ends the frame. `eof` and `eof_abort` pulse, the ENQ is not delivered, and no check is made.
- R8: In a frame without a check sequence, EOT (0x04) is delivered and ends the frame. A good `eof` pulses in the same cycle as that byte's `out_valid`.
- R9: A byte equal to the terminator ends the frame at once with a good `eof`; it is not delivered and no check is made. In non-transparent bodies this test follows the SYN drop and comes before ENQ, EOT and block-end decoding. In transparent bodies it applies only to a byte that is not DLE and does not follow a DLE. A value of 0xFF detects an idle line.
- R10: The terminator is 0x10 after reset and after `init`. A cycle with `cfg_term_wr` high loads `cfg_term_val`, and the new value applies from the next cycle; `init` wins over a write.
- R11: After any end of frame `hunting` is 1, and a fresh SYN pair is needed before any further byte is delivered.
- R12: In a transparent frame, a DLE followed by a byte equal to the terminator delivers that byte as data and does not end the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Initialize command: back to hunt, terminator to default |
| rx_stb | input | 1 | Qualifies `rx_byte` for one cycle |
| rx_byte | input | 8 | Received character |
| cfg_crc | input | 1 | 1 selects CRC-16, 0 selects LRC |
| cfg_term_wr | input | 1 | Load strobe for the terminator |
| cfg_term_val | input | 8 | New terminator value |
| out_valid | output | 1 | Delivered byte is valid |
| out_data | output | 8 | Delivered byte |
| eof | output | 1 | End-of-frame pulse |
| eof_bcc_err | output | 1 | Check mismatch, valid with `eof` |
| eof_abort | output | 1 | Abort, valid with `eof` |
| hunting | output | 1 | Receiver is looking for a SYN pair |

## Verification
The assertions assume that `rx_stb` lasts one cycle per character and that `init` is a single-cycle pulse. They also assume that `cfg_crc` holds still from a frame's opening byte to its last check byte. The stimulus sends each character as a one-cycle strobe with an idle cycle after it. It changes `cfg_crc` and the terminator only between frames, and it pulses `init` only between frames. Under those conditions, every delivery must trace back to a strobe taken while the controller was synchronized. Every end-of-frame pulse must also leave the receiver hunting with at most one qualifier set.

// File: rtl/bisync_rx_pkg.sv
package bisync_rx_pkg;

    localparam int CHAR_W = 8;
    localparam int CRC_W  = 16;

    localparam logic [CHAR_W-1:0] C_SOH = 8'h01;
    localparam logic [CHAR_W-1:0] C_STX = 8'h02;
    localparam logic [CHAR_W-1:0] C_ETX = 8'h03;
    localparam logic [CHAR_W-1:0] C_EOT = 8'h04;
    localparam logic [CHAR_W-1:0] C_ENQ = 8'h05;
    localparam logic [CHAR_W-1:0] C_DLE = 8'h10;
    localparam logic [CHAR_W-1:0] C_SYN = 8'h16;
    localparam logic [CHAR_W-1:0] C_ETB = 8'h17;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_SYN1,
        ST_SYNC,
        ST_XSTART,
        ST_NOBCC,
        ST_TEXT,
        ST_TRANS,
        ST_TRANS_DLE,
        ST_CHK1,
        ST_CHK2
    } rx_state_e;

    typedef enum logic [2:0] {
        K_DROP,
        K_TERM,
        K_ABORT,
        K_EOT,
        K_BLOCK_END,
        K_DATA
    } char_kind_e;

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] data;
        logic              eof;
        logic              err;
        logic              abort;
    } rx_out_t;

    // One character folded into a reflected CRC, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0]  c,
        input logic [CHAR_W-1:0] b,
        input logic [CRC_W-1:0]  poly
    );
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < CHAR_W; i++) begin
            r = (r[0] ^ b[i]) ? ((r >> 1) ^ poly) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/bisync_rx_term.sv
module bisync_rx_term
    import bisync_rx_pkg::*;
#(
    parameter logic [CHAR_W-1:0] TERM_INIT = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              wr,
    input  logic [CHAR_W-1:0] val,
    output logic [CHAR_W-1:0] term_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            term_q <= TERM_INIT;
        end else if (init) begin
            term_q <= TERM_INIT;
        end else if (wr) begin
            term_q <= val;
        end
    end

    // R10: an initialize pulse always leaves the default terminator behind
    p_term_default_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init) |-> (term_q == TERM_INIT));

    // R10: without a write or init the terminator holds its value
    p_term_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(init) && !$past(wr)) |-> $stable(term_q));

endmodule

// File: rtl/bisync_rx_bcc.sv
module bisync_rx_bcc
    import bisync_rx_pkg::*;
#(
    parameter logic [CRC_W-1:0] CRC_POLY = 16'hA001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [CHAR_W-1:0] din,
    output logic [CRC_W-1:0]  crc_q,
    output logic [CHAR_W-1:0] lrc_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
            lrc_q <= '0;
        end else if (clr) begin
            crc_q <= '0;
            lrc_q <= '0;
        end else if (add) begin
            crc_q <= crc_step(crc_q, din, CRC_POLY);
            lrc_q <= lrc_q ^ din;
        end
    end

    // R2: a frame opening leaves both accumulators empty
    p_clear_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (crc_q == '0 && lrc_q == '0));

    // R6: accumulators move only when a counted byte is added
    p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && !$past(add)) |-> ($stable(crc_q) && $stable(lrc_q)));

endmodule

// File: rtl/bisync_rx_fsm.sv
module bisync_rx_fsm
    import bisync_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              rx_stb,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              cfg_crc,
    input  logic [CHAR_W-1:0] term,
    input  logic [CRC_W-1:0]  crc,
    input  logic [CHAR_W-1:0] lrc,
    output logic              bcc_clr,
    output logic              bcc_add,
    output rx_out_t           out_q,
    output logic              hunting
);

    rx_state_e         st_q, st_d;
    rx_out_t           o_d;
    logic [CHAR_W-1:0] chk_lo_q;
    logic              chk_save;
    char_kind_e        nt_kind;
    logic              is_syn, is_dle, is_stx, is_blk_end, in_text;

    assign is_syn     = (rx_byte == C_SYN);
    assign is_dle     = (rx_byte == C_DLE);
    assign is_stx     = (rx_byte == C_STX);
    assign is_blk_end = (rx_byte == C_ETX) || (rx_byte == C_ETB);
    assign in_text    = (st_q == ST_TEXT);

    // Decode of one body character outside transparent mode.
    always_comb begin
        if (is_syn)                    nt_kind = K_DROP;
        else if (rx_byte == term)      nt_kind = K_TERM;
        else if (rx_byte == C_ENQ)     nt_kind = K_ABORT;
        else if (!in_text && rx_byte == C_EOT) nt_kind = K_EOT;
        else if (in_text && is_blk_end) nt_kind = K_BLOCK_END;
        else                           nt_kind = K_DATA;
    end

    always_comb begin
        st_d     = st_q;
        o_d      = '0;
        bcc_clr  = 1'b0;
        bcc_add  = 1'b0;
        chk_save = 1'b0;
        if (rx_stb) begin
            unique case (st_q)
                ST_HUNT: begin
                    if (is_syn) st_d = ST_SYN1;
                end
                ST_SYN1: begin
                    st_d = is_syn ? ST_SYNC : ST_HUNT;
                end
                ST_SYNC, ST_NOBCC, ST_TEXT: begin
                    if (st_q == ST_SYNC && is_syn) begin
                        st_d = ST_SYNC;
                    end else if (st_q == ST_SYNC && (is_stx || rx_byte == C_SOH)) begin
                        o_d.valid = 1'b1;
                        o_d.data  = rx_byte;
                        bcc_clr   = 1'b1;
                        st_d      = ST_TEXT;
                    end else if (st_q == ST_SYNC && is_dle) begin
                        st_d = ST_XSTART;
                    end else begin
                        if (st_q == ST_SYNC) bcc_clr = 1'b1;
                        st_d = in_text ? ST_TEXT : ST_NOBCC;
                        unique case (nt_kind)
                            K_DROP: begin
                                st_d = in_text ? ST_TEXT : ST_NOBCC;
                            end
                            K_TERM: begin
                                o_d.eof = 1'b1;
                                st_d    = ST_HUNT;
                            end
                            K_ABORT: begin
                                o_d.eof   = 1'b1;
                                o_d.abort = 1'b1;
                                st_d      = ST_HUNT;
                            end
                            K_EOT: begin
                                o_d.valid = 1'b1;
                                o_d.data  = rx_byte;
                                o_d.eof   = 1'b1;
                                st_d      = ST_HUNT;
                            end
                            K_BLOCK_END: begin
                                o_d.valid = 1'b1;
                                o_d.data  = rx_byte;
                                bcc_add   = 1'b1;
                                st_d      = ST_CHK1;
                            end
                            default: begin
                                o_d.valid = 1'b1;
                                o_d.data  = rx_byte;
                                bcc_add   = in_text;
                            end
                        endcase
                    end
                end
                ST_XSTART: begin
                    if (is_stx) begin
                        o_d.valid = 1'b1;
                        o_d.data  = rx_byte;
                        bcc_clr   = 1'b1;
                        st_d      = ST_TRANS;
                    end else begin
                        o_d.eof   = 1'b1;
                        o_d.abort = 1'b1;
                        st_d      = ST_HUNT;
                    end
                end
                ST_TRANS: begin
                    if (is_dle) begin
                        st_d = ST_TRANS_DLE;
                    end else if (rx_byte == term) begin
                        o_d.eof = 1'b1;
                        st_d    = ST_HUNT;
                    end else begin
                        o_d.valid = 1'b1;
                        o_d.data  = rx_byte;
                        bcc_add   = 1'b1;
                    end
                end
                ST_TRANS_DLE: begin
                    st_d = ST_TRANS;
                    if (is_syn) begin
                        st_d = ST_TRANS;
                    end else if (rx_byte == C_ENQ) begin
                        o_d.eof   = 1'b1;
                        o_d.abort = 1'b1;
                        st_d      = ST_HUNT;
                    end else begin
                        o_d.valid = 1'b1;
                        o_d.data  = rx_byte;
                        bcc_add   = 1'b1;
                        if (is_blk_end) st_d = ST_CHK1;
                    end
                end
                ST_CHK1: begin
                    if (cfg_crc) begin
                        chk_save = 1'b1;
                        st_d     = ST_CHK2;
                    end else begin
                        o_d.eof = 1'b1;
                        o_d.err = (rx_byte != lrc);
                        st_d    = ST_HUNT;
                    end
                end
                ST_CHK2: begin
                    o_d.eof = 1'b1;
                    o_d.err = (chk_lo_q != crc[CHAR_W-1:0]) ||
                              (rx_byte != crc[CRC_W-1:CHAR_W]);
                    st_d    = ST_HUNT;
                end
                default: st_d = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    st_q <= ST_HUNT;
        else if (init) st_q <= ST_HUNT;
        else           st_q <= st_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    out_q <= '0;
        else if (init) out_q <= '0;
        else           out_q <= o_d;
    end

    // First received check byte in CRC mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        chk_lo_q <= '0;
        else if (chk_save) chk_lo_q <= rx_byte;
    end

    assign hunting = (st_q == ST_HUNT) || (st_q == ST_SYN1);

    // R3: a delivered byte always follows a strobe by one cycle
    p_valid_after_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.valid |-> $past(rx_stb));

    // R1: a byte taken while hunting is never delivered
    p_quiet_in_hunt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hunting) |-> !out_q.valid);

    // R11: every end of frame leaves the receiver hunting
    p_eof_to_hunt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.eof |-> hunting);

    // R7: abort and check error never qualify the same end of frame
    p_status_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_q.err && out_q.abort));

    // R6: qualifiers appear only with an end-of-frame pulse
    p_flags_with_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.err || out_q.abort) |-> out_q.eof);

endmodule

// File: rtl/bisync_rx.sv
module bisync_rx
    import bisync_rx_pkg::*;
#(
    parameter logic [7:0]  TERM_INIT = 8'h10,
    parameter logic [15:0] CRC_POLY  = 16'hA001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       rx_stb,
    input  logic [7:0] rx_byte,
    input  logic       cfg_crc,
    input  logic       cfg_term_wr,
    input  logic [7:0] cfg_term_val,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       eof,
    output logic       eof_bcc_err,
    output logic       eof_abort,
    output logic       hunting
);

    logic [CHAR_W-1:0] term_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CHAR_W-1:0] lrc_q;
    logic              bcc_clr, bcc_add;
    rx_out_t           out_q;

    bisync_rx_term #(.TERM_INIT(TERM_INIT)) u_term (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (init),
        .wr     (cfg_term_wr),
        .val    (cfg_term_val),
        .term_q (term_q)
    );

    bisync_rx_bcc #(.CRC_POLY(CRC_POLY)) u_bcc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bcc_clr | init),
        .add   (bcc_add),
        .din   (rx_byte),
        .crc_q (crc_q),
        .lrc_q (lrc_q)
    );

    bisync_rx_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (init),
        .rx_stb  (rx_stb),
        .rx_byte (rx_byte),
        .cfg_crc (cfg_crc),
        .term    (term_q),
        .crc     (crc_q),
        .lrc     (lrc_q),
        .bcc_clr (bcc_clr),
        .bcc_add (bcc_add),
        .out_q   (out_q),
        .hunting (hunting)
    );

    assign out_valid   = out_q.valid;
    assign out_data    = out_q.data;
    assign eof         = out_q.eof;
    assign eof_bcc_err = out_q.err;
    assign eof_abort   = out_q.abort;

endmodule

// File: tb/bisync_rx_bench.sv
module bisync_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init = 1'b0;
    logic       rx_stb = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       cfg_crc = 1'b0;
    logic       cfg_term_wr = 1'b0;
    logic [7:0] cfg_term_val = 8'h00;
    logic       out_valid, eof, eof_bcc_err, eof_abort, hunting;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    bisync_rx u_bisync_rx (
        .clk(clk), .rst_n(rst_n), .init(init), .rx_stb(rx_stb), .rx_byte(rx_byte),
        .cfg_crc(cfg_crc), .cfg_term_wr(cfg_term_wr), .cfg_term_val(cfg_term_val),
        .out_valid(out_valid), .out_data(out_data), .eof(eof),
        .eof_bcc_err(eof_bcc_err), .eof_abort(eof_abort), .hunting(hunting)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    localparam int M_HUNT = 0, M_ONE = 1, M_SYNCED = 2, M_XDLE = 3, M_PLAIN = 4,
                   M_TEXT = 5, M_TR = 6, M_TRD = 7, M_CK1 = 8, M_CK2 = 9;
    int         m_mode;
    logic [7:0] m_term, chk0;
    logic [7:0] counted[$];
    logic       e_valid, e_eof, e_err, e_abort, e_hunt;
    logic [7:0] e_data;

    function automatic logic [15:0] crc_of(input logic [7:0] q[$]);
        logic [15:0] c = 16'h0000;
        foreach (q[i]) begin
            c = c ^ {8'h00, q[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        end
        return c;
    endfunction

    function automatic logic [7:0] lrc_of(input logic [7:0] q[$]);
        logic [7:0] x = 8'h00;
        foreach (q[i]) x = x ^ q[i];
        return x;
    endfunction

    task automatic give(input logic [7:0] b, input bit counts);
        e_valid = 1; e_data = b;
        if (counts) counted.push_back(b);
    endtask

    task automatic finish(input bit err, input bit ab);
        e_eof = 1; e_err = err; e_abort = ab; m_mode = M_HUNT;
    endtask

    task automatic plain(input logic [7:0] b);
        bit text = (m_mode == M_TEXT);
        if (b == 8'h16) begin end
        else if (b == m_term) finish(0, 0);
        else if (b == 8'h05) finish(0, 1);
        else if (!text && b == 8'h04) begin give(b, 0); finish(0, 0); end
        else if (text && (b == 8'h03 || b == 8'h17)) begin give(b, 1); m_mode = M_CK1; end
        else give(b, text);
    endtask

    task automatic model_byte(input logic [7:0] b);
        case (m_mode)
            M_HUNT: if (b == 8'h16) m_mode = M_ONE;
            M_ONE: m_mode = (b == 8'h16) ? M_SYNCED : M_HUNT;
            M_SYNCED: begin
                if (b == 8'h16) begin end
                else if (b == 8'h01 || b == 8'h02) begin give(b, 0); counted.delete(); m_mode = M_TEXT; end
                else if (b == 8'h10) m_mode = M_XDLE;
                else begin counted.delete(); m_mode = M_PLAIN; plain(b); end
            end
            M_PLAIN, M_TEXT: plain(b);
            M_XDLE: begin
                if (b == 8'h02) begin give(b, 0); counted.delete(); m_mode = M_TR; end
                else finish(0, 1);
            end
            M_TR: begin
                if (b == 8'h10) m_mode = M_TRD;
                else if (b == m_term) finish(0, 0);
                else give(b, 1);
            end
            M_TRD: begin
                m_mode = M_TR;
                if (b == 8'h16) begin end
                else if (b == 8'h05) finish(0, 1);
                else begin
                    give(b, 1);
                    if (b == 8'h03 || b == 8'h17) m_mode = M_CK1;
                end
            end
            M_CK1: begin
                if (cfg_crc) begin chk0 = b; m_mode = M_CK2; end
                else finish(b != lrc_of(counted), 0);
            end
            M_CK2: finish({b, chk0} != crc_of(counted), 0);
            default: m_mode = M_HUNT;
        endcase
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = M_HUNT; m_term = 8'h10; counted.delete();
            e_valid = 0; e_eof = 0; e_err = 0; e_abort = 0; e_data = 0; e_hunt = 1;
        end else begin
            e_valid = 0; e_eof = 0; e_err = 0; e_abort = 0;
            if (init) begin
                m_mode = M_HUNT; m_term = 8'h10;
            end else begin
                if (rx_stb) model_byte(rx_byte);
                if (cfg_term_wr) m_term = cfg_term_val;
            end
            e_hunt = (m_mode == M_HUNT || m_mode == M_ONE);
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 out_valid", out_valid, e_valid);
            if (e_valid) check("R3 out_data", out_data, e_data);
            check("R6 eof", eof, e_eof);
            check("R6 eof_bcc_err", eof_bcc_err, e_err);
            check("R7 eof_abort", eof_abort, e_abort);
            check("R11 hunting", hunting, e_hunt);
        end
    end

    // Directed frame tracking
    int d_cnt = 0;
    bit d_eof = 0, d_err = 0, d_ab = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) d_cnt++;
            if (eof) begin d_eof = 1; d_err = eof_bcc_err; d_ab = eof_abort; end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_stb = 1; rx_byte = b;
        @(negedge clk); rx_stb = 0;
    endtask

    task automatic begin_frame();
        @(negedge clk); d_cnt = 0; d_eof = 0; d_err = 0; d_ab = 0;
    endtask

    task automatic expect_end(input string req, input int n, input bit err, input bit ab);
        @(negedge clk); @(negedge clk);
        check({req, " eof seen"}, d_eof, 1);
        check({req, " bytes delivered"}, d_cnt, n);
        check({req, " check error"}, d_err, err);
        check({req, " abort"}, d_ab, ab);
    endtask

    task automatic set_term(input logic [7:0] v);
        @(negedge clk); cfg_term_wr = 1; cfg_term_val = v;
        @(negedge clk); cfg_term_wr = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  q[$];
        logic [15:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset hunting", hunting, 1);
        check("R1 reset out_valid", out_valid, 0);
        check("R1 reset eof", eof, 0);

        // R1: broken SYN pair keeps hunting
        begin_frame();
        send(8'h41); send(8'h16); send(8'h41); send(8'h16); send(8'h42);
        @(negedge clk);
        check("R1 no delivery while hunting", d_cnt, 0);
        check("R1 still hunting", hunting, 1);

        // R2 R4 R6: text frame, LRC good (41^42^03 = 00)
        begin_frame();
        send(8'h16); send(8'h16); send(8'h16); send(8'h02);
        send(8'h41); send(8'h16); send(8'h42); send(8'h03); send(8'h00);
        expect_end("R6 lrc good", 4, 0, 0);

        // R6: LRC mismatch
        begin_frame();
        send(8'h16); send(8'h16); send(8'h01); send(8'h41); send(8'h03); send(8'h55);
        expect_end("R6 lrc bad", 3, 1, 0);

        // R6: CRC text frame good and bad
        cfg_crc = 1;
        q = '{8'h31, 8'h32, 8'h03};
        c = crc_of(q);
        begin_frame();
        send(8'h16); send(8'h16); send(8'h01); send(8'h31); send(8'h32); send(8'h03);
        send(c[7:0]); send(c[15:8]);
        expect_end("R6 crc good", 4, 0, 0);
        begin_frame();
        send(8'h16); send(8'h16); send(8'h01); send(8'h31); send(8'h32); send(8'h03);
        send(c[15:8]); send(c[7:0]);
        expect_end("R6 crc swapped", 4, 1, 0);

        // R5: transparent frame with DLE DLE, DLE SYN, escaped data
        q = '{8'h10, 8'h55, 8'h03};
        c = crc_of(q);
        begin_frame();
        send(8'h16); send(8'h16); send(8'h10); send(8'h02);
        send(8'h10); send(8'h10); send(8'h10); send(8'h16); send(8'h55);
        send(8'h10); send(8'h03); send(c[7:0]); send(c[15:8]);
        expect_end("R5 transparent", 4, 0, 0);
        cfg_crc = 0;

        // R2: DLE without STX aborts
        begin_frame();
        send(8'h16); send(8'h16); send(8'h10); send(8'h41);
        expect_end("R2 bad transparent start", 0, 0, 1);

        // R9 R12: terminator in transparent body
        set_term(8'h7E);
        begin_frame();
        send(8'h16); send(8'h16); send(8'h10); send(8'h02);
        send(8'h10); send(8'h7E); send(8'h7E);
        expect_end("R12 escaped terminator", 2, 0, 0);

        // R7: ENQ aborts text frame
        begin_frame();
        send(8'h16); send(8'h16); send(8'h02); send(8'h41); send(8'h05);
        expect_end("R7 enq abort", 2, 0, 1);

        // R8: EOT ends a no-check frame
        begin_frame();
        send(8'h16); send(8'h16); send(8'h41); send(8'h16); send(8'h04);
        expect_end("R8 eot end", 2, 0, 0);

        // R9: idle terminator 0xFF
        set_term(8'hFF);
        begin_frame();
        send(8'h16); send(8'h16); send(8'h02); send(8'h41); send(8'hFF);
        expect_end("R9 idle terminator", 2, 0, 0);

        // R10: init restores DLE as terminator
        @(negedge clk); init = 1; @(negedge clk); init = 0;
        begin_frame();
        send(8'h16); send(8'h16); send(8'h02); send(8'h41); send(8'h10);
        expect_end("R10 default terminator", 2, 0, 0);

        // R11: after the end, bytes are ignored until a new SYN pair
        begin_frame();
        send(8'h41); send(8'h16); send(8'h42);
        @(negedge clk);
        check("R11 nothing after end", d_cnt, 0);
        check("R11 hunting after end", hunting, 1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule